// File: doc/BRIEF.md
# Link Rate and Lane Count Selector

This block picks a serial link configuration for a video mode. Given the pixel clock of the mode in kHz, the colour depth of the sink, the highest link rate and lane count the sink supports, and a flag that says the output drives a bridge device, it searches for the cheapest configuration whose payload bandwidth carries the pixel stream. Cheapest means the lowest link rate first and then the fewest lanes at that rate.

A search starts with a one-cycle `start` pulse, which also captures all the request inputs. The block then tests one candidate per clock cycle. When it finishes, it raises `done` for one cycle and presents the lane count and rate, or a failure flag. A separate `mode_ok` output also rejects a result that needs the top rate when the sink lacks version-1.2 capability. The result stays on the outputs until the next search completes.

Top module: `link_cfg_search`

## Requirements
- R1: Bits per pixel is 24 when `depth` is zero, and three times `depth` otherwise.
- R2: Outside bridge mode, the candidate rates are 162000, 270000 and 540000 kHz, tried in ascending order. Once a rate exceeds `sink_max_rate`, that rate and all higher ones are skipped.
- R3: At each rate, lane counts 1, 2 and 4 are tried in that order. A lane count above `sink_max_lanes` is never tried or reported.
- R4: A candidate is accepted when floor(lanes × rate × 8 / bpp) ≥ `pix_khz`. The first accepted candidate in search order is the result.
- R5: In bridge mode, only the 270000 kHz rate is tried, whatever the value of `sink_max_rate`.
- R6: When no candidate is accepted, `fail` is 1 and both `lanes` and `rate_khz` are 0. On success, `fail` is 0.
- R7: `mode_ok` is 1 only on success, and is 0 when the chosen rate is 540000 and `sink_v12` was 0 at start.
- R8: A `start` that arrives while `busy` is high is ignored. `done` is high for exactly one cycle per search. The outputs change only in the cycle in which `done` is high.
- R9: After reset, `busy`, `done`, `fail` and `mode_ok` are 0, and `lanes` and `rate_khz` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search and captures the inputs below |
| pix_khz | input | PIX_W | Requested pixel clock in kHz |
| depth | input | DEPTH_W | Bits per colour component; 0 selects the default |
| sink_max_rate | input | RATE_W | Highest link rate the sink supports, in kHz |
| sink_max_lanes | input | LANE_W | Highest lane count the sink supports |
| bridge_mode | input | 1 | Restricts the search to 270000 kHz |
| sink_v12 | input | 1 | Sink is version-1.2 capable |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| fail | output | 1 | No configuration fits |
| lanes | output | LANE_W+1 | Chosen lane count (1, 2 or 4), or 0 |
| rate_khz | output | RATE_W | Chosen link rate in kHz, or 0 |
| mode_ok | output | 1 | Result is usable with this sink |

## Verification
The hardest cases to reach are the exact truncation boundary and the limit cases. At the truncation boundary, a pixel clock one above floor(lanes × rate × 8 / bpp) must move the result to the next candidate. In the limit cases, a lane maximum of 3, 0 or more than 4, or a rate maximum between two candidate rates, cuts the search short. The bench reaches these by sweeping every lane maximum, several rate maxima, both modes and several depths against pixel clocks placed on and just past computed boundaries. A second start pulse issued while a search is running, with different inputs, shows that the first request alone decides the result.

// File: rtl/link_cfg_search.sv
module link_cfg_search #(
  parameter int PIX_W   = 20,
  parameter int DEPTH_W = 4,
  parameter int RATE_W  = 20,
  parameter int LANE_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PIX_W-1:0]    pix_khz,
  input  logic [DEPTH_W-1:0]  depth,
  input  logic [RATE_W-1:0]   sink_max_rate,
  input  logic [LANE_W-1:0]   sink_max_lanes,
  input  logic                bridge_mode,
  input  logic                sink_v12,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [LANE_W:0]     lanes,
  output logic [RATE_W-1:0]   rate_khz,
  output logic                mode_ok
);
  localparam int BPP_W = DEPTH_W + 2;
  localparam int LHS_W = RATE_W + LANE_W + 4;
  localparam int RHS_W = PIX_W + BPP_W;
  localparam int CMP_W = (LHS_W > RHS_W) ? LHS_W : RHS_W;
  localparam logic [RATE_W-1:0] RATE_LO  = RATE_W'(162000);
  localparam logic [RATE_W-1:0] RATE_MID = RATE_W'(270000);
  localparam logic [RATE_W-1:0] RATE_HI  = RATE_W'(540000);

  logic [1:0]         ri;
  logic [LANE_W:0]    ln;
  logic [PIX_W-1:0]   pix_q;
  logic [BPP_W-1:0]   bpp_q;
  logic [RATE_W-1:0]  maxr_q;
  logic [LANE_W-1:0]  maxl_q;
  logic               brg_q, v12_q;

  logic [RATE_W-1:0]  cur_rate;
  logic               rate_ok, lane_ok, fits;
  logic [CMP_W-1:0]   lhs, rhs;
  logic [BPP_W-1:0]   bpp_in;

  assign bpp_in = (depth == '0) ? BPP_W'(24) : BPP_W'(depth) * BPP_W'(3);

  always_comb begin
    case (ri)
      2'd0:    cur_rate = RATE_LO;
      2'd1:    cur_rate = RATE_MID;
      2'd2:    cur_rate = RATE_HI;
      default: cur_rate = '0;
    endcase
  end

  assign rate_ok = brg_q ? 1'b1 : ((ri != 2'd3) && (cur_rate <= maxr_q));
  assign lane_ok = (ln <= {1'b0, maxl_q});
  assign lhs     = (CMP_W'(ln) * CMP_W'(cur_rate)) << 3;
  assign rhs     = CMP_W'(pix_q) * CMP_W'(bpp_q);
  assign fits    = (lhs >= rhs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      lanes    <= '0;
      rate_khz <= '0;
      mode_ok  <= 1'b0;
      ri       <= '0;
      ln       <= '0;
      pix_q    <= '0;
      bpp_q    <= '0;
      maxr_q   <= '0;
      maxl_q   <= '0;
      brg_q    <= 1'b0;
      v12_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          pix_q  <= pix_khz;
          bpp_q  <= bpp_in;
          maxr_q <= sink_max_rate;
          maxl_q <= sink_max_lanes;
          brg_q  <= bridge_mode;
          v12_q  <= sink_v12;
          ri     <= bridge_mode ? 2'd1 : 2'd0;
          ln     <= (LANE_W+1)'(1);
        end
      end else if (!rate_ok || (!lane_ok && brg_q)) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        fail     <= 1'b1;
        lanes    <= '0;
        rate_khz <= '0;
        mode_ok  <= 1'b0;
      end else if (!lane_ok) begin
        ri <= ri + 2'd1;
        ln <= (LANE_W+1)'(1);
      end else if (fits) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        fail     <= 1'b0;
        lanes    <= ln;
        rate_khz <= cur_rate;
        mode_ok  <= !((cur_rate == RATE_HI) && !v12_q);
      end else begin
        ln <= ln << 1;
      end
    end
  end
endmodule

module link_cfg_search_props #(
  parameter int LANE_W = 3,
  parameter int RATE_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [LANE_W:0]   lanes,
  input logic [RATE_W-1:0] rate_khz,
  input logic              mode_ok
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(lanes) && $stable(rate_khz) && $stable(fail)) || !$past(rst_n));
  assert_fail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (lanes == '0 && rate_khz == '0));
  assert_lane_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> ($onehot(lanes) && lanes <= (LANE_W+1)'(4)));
  assert_rate_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (rate_khz == RATE_W'(162000) || rate_khz == RATE_W'(270000) ||
                         rate_khz == RATE_W'(540000)));
  assert_mode_needs_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok |-> !fail);
  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind link_cfg_search link_cfg_search_props #(.LANE_W(LANE_W), .RATE_W(RATE_W)) u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
  .lanes(lanes), .rate_khz(rate_khz), .mode_ok(mode_ok)
);

// File: tb/link_cfg_search_test.sv
module link_cfg_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pix_khz = '0;
  logic [3:0]  depth = '0;
  logic [19:0] sink_max_rate = '0;
  logic [2:0]  sink_max_lanes = '0;
  logic        bridge_mode = 1'b0;
  logic        sink_v12 = 1'b0;
  logic        busy, done, fail, mode_ok;
  logic [3:0]  lanes;
  logic [19:0] rate_khz;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  link_cfg_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz), .depth(depth),
    .sink_max_rate(sink_max_rate), .sink_max_lanes(sink_max_lanes),
    .bridge_mode(bridge_mode), .sink_v12(sink_v12), .busy(busy), .done(done),
    .fail(fail), .lanes(lanes), .rate_khz(rate_khz), .mode_ok(mode_ok)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not complete (actual %0d cycles, expected fewer)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int e_lanes, e_rate, e_fail, e_ok;

  task automatic model(input int pix, input int d, input int maxr, input int maxl,
                       input bit brg, input bit v12);
    int bpp;
    int rates[3];
    bit found;
    bpp = (d == 0) ? 24 : 3 * d;
    rates[0] = 162000; rates[1] = 270000; rates[2] = 540000;
    found = 0; e_lanes = 0; e_rate = 0;
    for (int i = 0; i < 3 && !found; i++) begin
      if (brg ? (i != 1) : (rates[i] > maxr)) continue;
      for (int l = 1; l <= maxl && !found; l = l * 2) begin
        if ((longint'(l) * rates[i] * 8) / bpp >= pix) begin
          found = 1; e_lanes = l; e_rate = rates[i];
        end
      end
      if (!brg && rates[i] > maxr) break;
    end
    e_fail = found ? 0 : 1;
    e_ok = (found && !(e_rate == 540000 && !v12)) ? 1 : 0;
  endtask

  task automatic run(input int pix, input int d, input int maxr, input int maxl,
                     input bit brg, input bit v12);
    int waitc;
    @(negedge clk);
    pix_khz = 20'(pix); depth = 4'(d); sink_max_rate = 20'(maxr);
    sink_max_lanes = 3'(maxl); bridge_mode = brg; sink_v12 = v12;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitc = 0;
    while (!done && waitc < 40) begin
      @(negedge clk);
      waitc++;
    end
    check("R8 done seen", done, 1);
  endtask

  task automatic compare(input string tag);
    check({tag, " lanes R3"}, lanes, e_lanes);
    check({tag, " rate R2"}, rate_khz, e_rate);
    check({tag, " fail R6"}, fail, e_fail);
    check({tag, " mode_ok R7"}, mode_ok, e_ok);
  endtask

  initial begin
    int pixes[7];
    int maxrs[4];
    int depths[4];
    logic [3:0] held_l;
    logic [19:0] held_r;
    pixes[0] = 1000; pixes[1] = 61714; pixes[2] = 61715; pixes[3] = 100000;
    pixes[4] = 300000; pixes[5] = 700000; pixes[6] = 1000000;
    maxrs[0] = 100000; maxrs[1] = 162000; maxrs[2] = 300000; maxrs[3] = 540000;
    depths[0] = 0; depths[1] = 6; depths[2] = 7; depths[3] = 10;

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 fail", fail, 0);
    check("R9 lanes", lanes, 0);
    check("R9 rate", rate_khz, 0);
    check("R9 mode_ok", mode_ok, 0);
    rst_n = 1'b1;

    // R4 truncation boundary: bpp 21, 1 lane at 162000 carries floor(61714.28)
    run(61714, 7, 540000, 4, 0, 1);
    check("R4 boundary lanes", lanes, 1);
    check("R4 boundary rate", rate_khz, 162000);
    run(61715, 7, 540000, 4, 0, 1);
    check("R4 past boundary lanes", lanes, 2);

    // R1 default depth equals depth 8
    run(54000, 0, 540000, 4, 0, 1);
    check("R1 default bpp lanes", lanes, 1);
    run(54001, 0, 540000, 4, 0, 1);
    check("R1 default bpp past lanes", lanes, 2);
    run(54001, 8, 540000, 4, 0, 1);
    check("R1 depth 8 lanes", lanes, 2);

    // R5 bridge ignores rate limit
    run(1000, 8, 100000, 4, 1, 1);
    check("R5 bridge rate", rate_khz, 270000);
    check("R5 bridge fail", fail, 0);

    // R7 top rate without v12 capability
    run(700000, 8, 540000, 4, 0, 0);
    check("R7 top rate", rate_khz, 540000);
    check("R7 mode rejected", mode_ok, 0);

    // R8 start while busy is ignored, done is one cycle, result held
    @(negedge clk);
    pix_khz = 20'd700000; depth = 4'd8; sink_max_rate = 20'd540000;
    sink_max_lanes = 3'd4; bridge_mode = 1'b0; sink_v12 = 1'b1;
    start = 1'b1;
    @(negedge clk);
    pix_khz = 20'd1000;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R8 ignored start lanes", lanes, 4);
    check("R8 ignored start rate", rate_khz, 540000);
    held_l = lanes; held_r = rate_khz;
    @(negedge clk);
    check("R8 done width", done, 0);
    pix_khz = 20'd5; depth = 4'd1;
    repeat (4) @(negedge clk);
    check("R8 held lanes", lanes, held_l);
    check("R8 held rate", rate_khz, held_r);
    check("R8 idle", busy, 0);

    // sweep
    for (int b = 0; b < 2; b++)
      for (int ml = 0; ml < 8; ml++)
        for (int mr = 0; mr < 4; mr++)
          for (int di = 0; di < 4; di++)
            for (int pi = 0; pi < 7; pi++) begin
              model(pixes[pi], depths[di], maxrs[mr], ml, b[0], pi[0]);
              run(pixes[pi], depths[di], maxrs[mr], ml, b[0], pi[0]);
              compare(b[0] ? "R5 sweep R4" : "R1 sweep R4");
            end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule